// File: doc/BRIEF.md
# Setup-Driven Conversion Sequencer

This block schedules the conversions and calibrations of a converter front end. Sixteen 12-bit setup words are stored inside it. Each word names an input channel, a gain code, a word-rate code, the polarity and the state of two general-purpose latch pins. An operation command either executes one setup, or starts a scan over setups 0 to a configured depth. A scan runs once or repeats. For the setup being executed, the block drives the analog-side selects and runs a timer whose length comes from the word-rate code. When the timer ends, the block captures the result word that the modulator and filter model presents.

Conversion results enter an eight-entry first-in first-out store that a host drains. Calibration operations use the same timing but store nothing. A flag reports that a conversion, a calibration or a scan pass has completed, and a sticky flag reports results lost to a full store.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `scan_done`, `conv_end` and `fifo_ovf` are 0, the store is empty, and every setup-driven output is 0.
- R2: A command byte is acted on only when bit 7 is 1. Bits 6..3 then select a setup and bits 2..0 select the operation. With `cfg_multi` low, code 000 converts the selected setup once, pushes `result_data` and returns to idle. Bytes with bit 7 at 0 have no effect, even during a conversion.
- R3: While a setup executes, the outputs carry its fields: bits 11..10 drive `latch_out`, bits 9..7 `chan_sel`, bits 6..4 `rate_sel`, bits 3..1 `gain_sel` and bit 0 `unipolar`. These outputs stay stable within a conversion.
- R4: A conversion lasts 2180, 1092, 532, 388, 324, 17444, 8724 or 4364 cycles for rate codes 0 to 7. The first conversion after an accepted command lasts 7 cycles more.
- R5: With `cfg_multi` high, a code-000 command ignores its pointer and converts setups 0 through `cfg_depth` in ascending order, pushing each result.
- R6: `scan_done` rises when a single operation or a scan pass completes. With `cfg_loop` low the block then goes idle. With `cfg_loop` high it restarts, at setup 0 for a scan or on the same setup for a single conversion, until another operation command arrives.
- R7: Codes 001, 010, 101 and 110 are calibrations. Each runs the pointed setup once, with the same timing as a conversion, pushes nothing, and ignores `cfg_multi` and `cfg_loop`. `cur_op` shows the running code.
- R8: A reserved code (011, 100, 111) with bit 7 set stops any activity. The block is idle one cycle later, and the interrupted conversion pushes nothing.
- R9: A valid operation command that arrives while busy abandons the current conversion without a push and starts the new operation, including the 7-cycle first-conversion extension.
- R10: The store holds 8 results and returns them in arrival order. `fifo_rdata` always shows the oldest entry, and `fifo_rd` removes it.
- R11: A result that arrives while the store is full is dropped and sets `fifo_ovf`. The flag clears when a read empties the store.
- R12: `scan_done` clears when a command with bit 7 set is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| cfg_multi | input | 1 | Scan setups 0..cfg_depth on a code-000 command |
| cfg_loop | input | 1 | Repeat instead of stopping after one pass |
| cfg_depth | input | 4 | Index of the last setup in a scan |
| setup_we | input | 1 | Setup store write enable |
| setup_addr | input | 4 | Setup store write address |
| setup_wdata | input | 12 | Setup word to write |
| result_data | input | DW | Result word from the modulator model |
| busy | output | 1 | An operation is executing |
| cur_op | output | 3 | Code of the executing operation |
| chan_sel | output | 3 | Channel select of the current setup |
| rate_sel | output | 3 | Word-rate code of the current setup |
| gain_sel | output | 3 | Gain code of the current setup |
| unipolar | output | 1 | 1 = unipolar, 0 = bipolar |
| latch_out | output | 2 | Latch pins of the current setup |
| conv_end | output | 1 | One-cycle pulse after each completed conversion or calibration |
| scan_done | output | 1 | Completion flag |
| fifo_rd | input | 1 | Remove the oldest result |
| fifo_rdata | output | DW | Oldest result |
| fifo_count | output | 4 | Results held |
| fifo_empty | output | 1 | Store empty |
| fifo_ovf | output | 1 | A result was dropped |

## Verification
Every setup word written into the store is also kept in the bench, and the result word fed to the block is assembled from the setup outputs. Each stored result therefore identifies the setup that produced it. A design that ignores the pointer during a scan, starts at the wrong index or skips the wrap back to setup 0 in loop mode stores results in an order that differs from the expected one. A scan across all eight rate codes with a total-cycle count catches a wrong entry in the length table or a misplaced 7-cycle extension. That scan also fills the store exactly, so a full flag that fires one entry early fails the test. Aborting by a reserved code and by a new command checks that an interrupted conversion leaves no result behind, and a mid-conversion byte with bit 7 clear must not change the timing. An overflow run checks that extra results are dropped rather than written over the oldest ones.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int SETUP_W  = 12;
  localparam int SETUP_AW = 4;
  localparam int CNT_W    = 15;
  localparam int FIRST_EXTRA = 7;

  localparam logic [2:0] OP_CONV  = 3'b000;
  localparam logic [2:0] OP_SOFF  = 3'b001;
  localparam logic [2:0] OP_SGAIN = 3'b010;
  localparam logic [2:0] OP_YOFF  = 3'b101;
  localparam logic [2:0] OP_YGAIN = 3'b110;

  typedef struct packed {
    logic [1:0] latch;
    logic [2:0] chan;
    logic [2:0] rate;
    logic [2:0] gain;
    logic       unipolar;
  } setup_t;

  function automatic logic op_known(input logic [2:0] op);
    return (op == OP_CONV) || (op == OP_SOFF) || (op == OP_SGAIN) ||
           (op == OP_YOFF) || (op == OP_YGAIN);
  endfunction

  function automatic logic [CNT_W-1:0] rate_cycles(input logic [2:0] r);
    logic [CNT_W-1:0] n;
    case (r)
      3'd0:    n = CNT_W'(2180);
      3'd1:    n = CNT_W'(1092);
      3'd2:    n = CNT_W'(532);
      3'd3:    n = CNT_W'(388);
      3'd4:    n = CNT_W'(324);
      3'd5:    n = CNT_W'(17444);
      3'd6:    n = CNT_W'(8724);
      default: n = CNT_W'(4364);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/setup_store.sv
module setup_store #(
  parameter int WIDTH = 12,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [WIDTH-1:0] mem [ENTRIES];

  initial begin
    for (int i = 0; i < ENTRIES; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, do_pop, do_push;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && !do_push)                          ovf <= 1'b1;
      else if (do_pop && count == CW'(1) && !do_push) ovf <= 1'b0;
    end
  end

  assign rdata = mem[rp];

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_ovf_set_r11: assert property (@(posedge clk) disable iff (rst)
    (push && count == CW'(DEPTH) && !pop) |=> ovf);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int DW         = 24,
  parameter int FIFO_DEPTH = 8,
  localparam int FCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [7:0]          cmd_byte,
  input  logic                cfg_multi,
  input  logic                cfg_loop,
  input  logic [SETUP_AW-1:0] cfg_depth,
  input  logic                setup_we,
  input  logic [SETUP_AW-1:0] setup_addr,
  input  logic [SETUP_W-1:0]  setup_wdata,
  input  logic [DW-1:0]       result_data,
  output logic                busy,
  output logic [2:0]          cur_op,
  output logic [2:0]          chan_sel,
  output logic [2:0]          rate_sel,
  output logic [2:0]          gain_sel,
  output logic                unipolar,
  output logic [1:0]          latch_out,
  output logic                conv_end,
  output logic                scan_done,
  input  logic                fifo_rd,
  output logic [DW-1:0]       fifo_rdata,
  output logic [FCW-1:0]      fifo_count,
  output logic                fifo_empty,
  output logic                fifo_ovf
);

  logic                cmd_go, op_ok, is_cal, multi_eff;
  logic [2:0]          cmd_op;
  logic [SETUP_AW-1:0] cmd_ptr, start_idx, rd_addr, idx, run_depth;
  logic                run_multi, run_loop, last, finish, again;
  logic                tmr_load, tmr_zero, push;
  logic [CNT_W-1:0]    tmr_val, base_len;
  logic [SETUP_W-1:0]  rd_raw;
  setup_t              rd_word, cur_setup;
  logic [2:0]          run_op;

  assign cmd_go    = cmd_valid && cmd_byte[7];
  assign cmd_op    = cmd_byte[2:0];
  assign cmd_ptr   = cmd_byte[6:3];
  assign op_ok     = op_known(cmd_op);
  assign is_cal    = (cmd_op != OP_CONV);
  assign multi_eff = cfg_multi && !is_cal;
  assign start_idx = multi_eff ? '0 : cmd_ptr;

  assign finish = busy && tmr_zero;
  assign last   = !run_multi || (idx == run_depth);
  assign again  = !last || run_loop;

  always_comb begin
    if (cmd_go)          rd_addr = start_idx;
    else if (!run_multi) rd_addr = idx;
    else if (last)       rd_addr = '0;
    else                 rd_addr = idx + 1'b1;
  end

  setup_store #(.WIDTH(SETUP_W), .AW(SETUP_AW)) u_store (
    .clk   (clk),
    .we    (setup_we),
    .waddr (setup_addr),
    .wdata (setup_wdata),
    .raddr (rd_addr),
    .rdata (rd_raw)
  );

  assign rd_word  = setup_t'(rd_raw);
  assign base_len = rate_cycles(rd_word.rate);
  assign tmr_load = (cmd_go && op_ok) || (!cmd_go && finish && again);
  assign tmr_val  = cmd_go ? base_len + CNT_W'(FIRST_EXTRA - 1) : base_len - 1'b1;

  conv_timer #(.CW(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign push = finish && !cmd_go && (run_op == OP_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      run_op    <= OP_CONV;
      run_multi <= 1'b0;
      run_loop  <= 1'b0;
      run_depth <= '0;
      cur_setup <= '0;
      conv_end  <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      conv_end <= finish && !cmd_go;
      if (cmd_go) begin
        scan_done <= 1'b0;
        busy      <= op_ok;
        if (op_ok) begin
          idx       <= start_idx;
          run_op    <= cmd_op;
          run_multi <= multi_eff;
          run_loop  <= cfg_loop && !is_cal;
          run_depth <= cfg_depth;
          cur_setup <= rd_word;
        end
      end else if (finish) begin
        if (last) scan_done <= 1'b1;
        if (again) begin
          idx       <= rd_addr;
          cur_setup <= rd_word;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  assign cur_op    = run_op;
  assign latch_out = cur_setup.latch;
  assign chan_sel  = cur_setup.chan;
  assign rate_sel  = cur_setup.rate;
  assign gain_sel  = cur_setup.gain;
  assign unipolar  = cur_setup.unipolar;

  result_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (result_data),
    .pop   (fifo_rd),
    .rdata (fifo_rdata),
    .count (fifo_count),
    .empty (fifo_empty),
    .ovf   (fifo_ovf)
  );

  p_cal_no_push_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_op != OP_CONV) |=> (fifo_count <= $past(fifo_count)));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_zero && !cmd_valid) |=> $stable(latch_out) && $stable(chan_sel));

  p_reserved_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte[7] && !op_known(cmd_byte[2:0])) |=> !busy);

  p_done_stop_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(scan_done) && busy) |-> run_loop);

endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        cfg_multi = 1'b0, cfg_loop = 1'b0;
  logic [3:0]  cfg_depth = '0;
  logic        setup_we = 1'b0;
  logic [3:0]  setup_addr = '0;
  logic [11:0] setup_wdata = '0;
  logic [23:0] result_data;
  logic        busy, unipolar, conv_end, scan_done, fifo_rd, fifo_empty, fifo_ovf;
  logic [2:0]  cur_op, chan_sel, rate_sel, gain_sel;
  logic [1:0]  latch_out;
  logic [23:0] fifo_rdata;
  logic [3:0]  fifo_count;

  logic [11:0] sw [16];
  logic [11:0] tag = 12'h0;
  logic [23:0] expq [32];
  int          eq_n = 0;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  initial fifo_rd = 1'b0;

  assign result_data = {tag, latch_out, chan_sel, rate_sel, gain_sel, unipolar};

  conv_sequencer u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cfg_multi(cfg_multi), .cfg_loop(cfg_loop), .cfg_depth(cfg_depth),
    .setup_we(setup_we), .setup_addr(setup_addr), .setup_wdata(setup_wdata),
    .result_data(result_data), .busy(busy), .cur_op(cur_op),
    .chan_sel(chan_sel), .rate_sel(rate_sel), .gain_sel(gain_sel),
    .unipolar(unipolar), .latch_out(latch_out), .conv_end(conv_end),
    .scan_done(scan_done), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf)
  );

  function automatic int exp_len(input logic [2:0] r);
    case (r)
      3'd0: return 2180;  3'd1: return 1092;
      3'd2: return 532;   3'd3: return 388;
      3'd4: return 324;   3'd5: return 17444;
      3'd6: return 8724;  default: return 4364;
    endcase
  endfunction

  function automatic logic [11:0] rnd_setup(input logic [2:0] rate);
    logic [11:0] w;
    w = 12'($urandom);
    w[6:4] = rate;
    return w;
  endfunction

  function automatic logic [2:0] fast_rate();
    int k;
    k = int'($urandom % 3);
    return 3'(2 + k);
  endfunction

  function automatic logic [7:0] mk_cmd(input int ptr, input logic [2:0] op);
    return {1'b1, 4'(ptr), op};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_setup(input int a, input logic [11:0] w);
    @(negedge clk);
    setup_we = 1'b1; setup_addr = 4'(a); setup_wdata = w;
    @(negedge clk);
    setup_we = 1'b0;
    sw[a] = w;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy === 1'b1 && cyc < 60000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic expect_word(input int a);
    expq[eq_n] = {tag, sw[a]};
    eq_n++;
  endtask

  task automatic drain_check(input string req);
    chk(req, "fifo count", 32'(fifo_count), 32'(eq_n));
    for (int k = 0; k < eq_n; k++) begin
      chk(req, "fifo data", 32'(fifo_rdata), 32'(expq[k]));
      fifo_rd = 1'b1;
      @(negedge clk);
      fifo_rd = 1'b0;
    end
    eq_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, total, pulses, d, p;
    logic [2:0] op;
    logic [2:0] ops [5];
    ops = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b110};
    void'($urandom(32'd5821));
    for (int i = 0; i < 16; i++) sw[i] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "empty", 32'(fifo_empty), 1);
    chk("R1", "count", 32'(fifo_count), 0);
    chk("R1", "scan_done", 32'(scan_done), 0);
    chk("R1", "ovf", 32'(fifo_ovf), 0);
    chk("R1", "outputs", 32'({latch_out, chan_sel, rate_sel, gain_sel, unipolar}), 0);

    // R4 R5 R10: scan over all eight rate codes, fills store exactly
    total = 7;
    for (int i = 0; i < 8; i++) begin
      wr_setup(i, rnd_setup(3'(i)));
      total += exp_len(3'(i));
    end
    tag = 12'h101;
    cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'd7;
    send(mk_cmd(9, 3'b000));
    chk("R5", "first setup chan", 32'(chan_sel), 32'(sw[0][9:7]));
    wait_idle(cyc);
    chk("R4", "scan cycles", 32'(cyc), 32'(total));
    chk("R6", "scan_done after pass", 32'(scan_done), 1);
    chk("R11", "no ovf at exactly full", 32'(fifo_ovf), 0);
    for (int i = 0; i < 8; i++) expect_word(i);
    drain_check("R10");

    // R2 R3: single conversion on setup 11
    wr_setup(11, rnd_setup(fast_rate()));
    cfg_multi = 1'b0; tag = 12'h202;
    send(mk_cmd(11, 3'b000));
    chk("R12", "scan_done cleared", 32'(scan_done), 0);
    chk("R3", "latch", 32'(latch_out), 32'(sw[11][11:10]));
    chk("R3", "chan", 32'(chan_sel), 32'(sw[11][9:7]));
    chk("R3", "rate", 32'(rate_sel), 32'(sw[11][6:4]));
    chk("R3", "gain", 32'(gain_sel), 32'(sw[11][3:1]));
    chk("R3", "polarity", 32'(unipolar), 32'(sw[11][0]));
    wait_idle(cyc);
    chk("R4", "single cycles", 32'(cyc), 32'(exp_len(sw[11][6:4]) + 7));
    chk("R2", "done", 32'(scan_done), 1);
    expect_word(11);
    drain_check("R2");

    // R7: calibration ignores multi and loop, pushes nothing
    wr_setup(5, rnd_setup(fast_rate()));
    cfg_multi = 1'b1; cfg_loop = 1'b1; cfg_depth = 4'd3;
    send(mk_cmd(5, 3'b001));
    chk("R7", "cur_op", 32'(cur_op), 1);
    chk("R7", "chan", 32'(chan_sel), 32'(sw[5][9:7]));
    wait_idle(cyc);
    chk("R7", "cal cycles", 32'(cyc), 32'(exp_len(sw[5][6:4]) + 7));
    chk("R7", "no push", 32'(fifo_count), 0);
    chk("R7", "done", 32'(scan_done), 1);

    // R8: reserved code idle and as abort
    cfg_multi = 1'b0; cfg_loop = 1'b0;
    send(mk_cmd(2, 3'b011));
    chk("R8", "reserved stays idle", 32'(busy), 0);
    wr_setup(3, rnd_setup(3'd5));
    send(mk_cmd(3, 3'b000));
    repeat (20) @(negedge clk);
    send(mk_cmd(3, 3'b111));
    chk("R8", "reserved aborts", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk("R8", "no push after abort", 32'(fifo_count), 0);

    // R2: byte with bit 7 clear during a conversion has no effect
    wr_setup(6, rnd_setup(3'd4));
    tag = 12'h303;
    send(mk_cmd(6, 3'b000));
    cyc = 0;
    while (busy === 1'b1 && cyc < 60000) begin
      cyc++;
      if (cyc == 10) begin cmd_valid = 1'b1; cmd_byte = 8'h28; end
      else begin cmd_valid = 1'b0; cmd_byte = '0; end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk("R2", "bit7 clear ignored timing", 32'(cyc), 32'(exp_len(3'd4) + 7));
    expect_word(6);
    drain_check("R2");

    // R9: new command while busy restarts
    wr_setup(7, rnd_setup(3'd2));
    wr_setup(8, rnd_setup(3'd3));
    tag = 12'h404;
    send(mk_cmd(7, 3'b000));
    repeat (30) @(negedge clk);
    send(mk_cmd(8, 3'b000));
    wait_idle(cyc);
    chk("R9", "restart cycles", 32'(cyc), 32'(exp_len(3'd3) + 7));
    expect_word(8);
    drain_check("R9");

    // R6: loop scan over setups 0..2
    for (int i = 0; i < 3; i++) wr_setup(i, rnd_setup(fast_rate()));
    tag = 12'h505;
    cfg_multi = 1'b1; cfg_loop = 1'b1; cfg_depth = 4'd2;
    send(mk_cmd(4, 3'b000));
    pulses = 0;
    while (pulses < 7) begin
      @(negedge clk);
      if (conv_end === 1'b1) begin
        pulses++;
        if (pulses == 3) begin
          chk("R6", "done after first pass", 32'(scan_done), 1);
          chk("R6", "still looping", 32'(busy), 1);
        end
      end
    end
    send(mk_cmd(0, 3'b100));
    chk("R8", "loop stopped", 32'(busy), 0);
    for (int i = 0; i < 7; i++) expect_word(i % 3);
    drain_check("R6");

    // R11: overflow
    for (int i = 0; i < 10; i++) wr_setup(i, rnd_setup(fast_rate()));
    tag = 12'h606;
    cfg_loop = 1'b0; cfg_depth = 4'd9;
    send(mk_cmd(0, 3'b000));
    wait_idle(cyc);
    chk("R11", "ovf set", 32'(fifo_ovf), 1);
    for (int i = 0; i < 8; i++) expect_word(i);
    drain_check("R11");
    chk("R11", "ovf cleared on empty", 32'(fifo_ovf), 0);

    // random mix of single operations and short scans
    for (int it = 0; it < 14; it++) begin
      tag = 12'(16'h700 + it);
      if ($urandom % 2 == 0) begin
        p = int'($urandom % 16);
        op = ops[$urandom % 5];
        wr_setup(p, rnd_setup(fast_rate()));
        cfg_multi = 1'($urandom); cfg_loop = 1'b0;
        if (op != 3'b000) cfg_loop = 1'($urandom);
        send(mk_cmd(p, op));
        chk(op == 3'b000 ? "R2" : "R7", "random op", 32'(cur_op), 32'(op));
        wait_idle(cyc);
        if (op == 3'b000 && cfg_multi) begin
          total = 7;
          for (int i = 0; i <= int'(cfg_depth); i++) begin
            total += exp_len(sw[i][6:4]);
            expect_word(i);
          end
        end else begin
          total = exp_len(sw[p][6:4]) + 7;
          if (op == 3'b000) expect_word(p);
        end
        chk("R4", "random cycles", 32'(cyc), 32'(total));
      end else begin
        d = int'($urandom % 4);
        for (int i = 0; i <= d; i++) wr_setup(i, rnd_setup(fast_rate()));
        cfg_multi = 1'b1; cfg_loop = 1'b0; cfg_depth = 4'(d);
        send(mk_cmd(int'($urandom % 16), 3'b000));
        wait_idle(cyc);
        total = 7;
        for (int i = 0; i <= d; i++) begin
          total += exp_len(sw[i][6:4]);
          expect_word(i);
        end
        chk("R5", "random scan cycles", 32'(cyc), 32'(total));
      end
      drain_check("R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule